// File: doc/BRIEF.md
# Controller Bus Region Decoder with Local Memories

This block is the bus fabric that sits between a 16-bit controller core and everything the core can reach. Each access carries a 16-bit address and one of two strobes, read or write. The top five address bits pick a region. Two regions are served on chip: a 2048-word program ROM and a 2048-word data RAM. Two regions are windows to external devices: a sample buffer and a network controller. Any other region is unmapped and is answered at once with zero data.

The fabric returns read data from the selected source on a single read bus and raises an acknowledge. The core must hold its address, strobe and write data until it sees that acknowledge. The core's separate outgoing and incoming data buses meet a single bidirectional external bus. That bus is driven outward only during writes to an external window. At all other times it is an input.

The processor bus is a plain strobe/acknowledge interface, not a valid/ready stream. The core applies back-pressure by holding its strobe. The fabric stalls the core by withholding the acknowledge. Only one strobe may be active at a time.

Top module: `ctl_bus_fabric`

## Requirements
- R1: Region is `bus_addr[15:11]`: 0 is ROM, 1 is RAM, 2 is the sample window, 3 is the network window (so 0x1800 to 0x1FFF). `ext_sel_smp` is high exactly when a strobe is active in region 2, and `ext_sel_net` exactly when a strobe is active in region 3.
- R2: With neither strobe active, `ext_sel_smp`, `ext_sel_net` and `bus_ack` are low and `bus_rdata` is 0.
- R3: A RAM write stores `bus_wdata` at word index `bus_addr[10:0]`. A later RAM read of that index returns it, and writes to other indices leave it unchanged.
- R4: The ROM word at index i is ((i * 0x9E37) mod 65536) XOR 0x5A5A. A write strobe to the ROM region is acknowledged and leaves the contents unchanged.
- R5: For ROM or RAM, `bus_ack` is low in the first cycle of a strobe and high in the next one. On a read, `bus_rdata` holds the addressed word in that acknowledge cycle.
- R6: For either external window, `bus_ack` follows `ext_ready` in the same cycle, and a read returns the value present on `ext_data`.
- R7: `ext_drive` is high and `ext_data` carries `bus_wdata` only while a write strobe targets an external window. Otherwise the fabric leaves `ext_data` undriven, so an external value can be read in.
- R8: A strobe to regions 4 to 31 is acknowledged in the same cycle, selects no device and returns 0.
- R9: While `rst` is high, and in the first idle cycle after it, `bus_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Read strobe, held until acknowledge |
| bus_wr | input | 1 | Write strobe, held until acknowledge |
| bus_wdata | input | 16 | Processor write data |
| bus_rdata | output | 16 | Read data returned to the processor |
| bus_ack | output | 1 | Access complete |
| ext_ready | input | 1 | Ready from the external device being addressed |
| ext_sel_smp | output | 1 | Select for the sample-buffer window |
| ext_sel_net | output | 1 | Select for the network-controller window |
| ext_drive | output | 1 | High while the fabric drives `ext_data` |
| ext_data | inout | 16 | Bidirectional external data bus |

## Verification
The assertions assume that the core never raises both strobes together and that it holds its address and strobe steady until the acknowledge. The memory acknowledge timing relies on that holding. The stimulus keeps to this: every access raises exactly one strobe on a falling edge, holds it through the acknowledging cycle and then drops it. The bench drives `ext_data` only while no external write is in progress.

// File: rtl/fab_pkg.sv
package fab_pkg;
  typedef enum logic [2:0] {
    RG_IDLE,
    RG_ROM,
    RG_RAM,
    RG_SMP,
    RG_NET,
    RG_NONE
  } region_e;
endpackage

// File: rtl/fab_decode.sv
module fab_decode
  import fab_pkg::*;
#(
  parameter int AW       = 16,
  parameter int RW       = 5,
  parameter logic [RW-1:0] ROM_CODE = 5'd0,
  parameter logic [RW-1:0] RAM_CODE = 5'd1,
  parameter logic [RW-1:0] SMP_CODE = 5'd2,
  parameter logic [RW-1:0] NET_CODE = 5'd3
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output region_e       region,
  output logic          cs_rom,
  output logic          cs_ram,
  output logic          cs_smp,
  output logic          cs_net,
  output logic          cs_none
);
  logic [RW-1:0] code;
  assign code = addr[AW-1 -: RW];

  always_comb begin
    if (!(rd || wr))              region = RG_IDLE;
    else if (code == ROM_CODE)    region = RG_ROM;
    else if (code == RAM_CODE)    region = RG_RAM;
    else if (code == SMP_CODE)    region = RG_SMP;
    else if (code == NET_CODE)    region = RG_NET;
    else                          region = RG_NONE;
  end

  assign cs_rom  = (region == RG_ROM);
  assign cs_ram  = (region == RG_RAM);
  assign cs_smp  = (region == RG_SMP);
  assign cs_net  = (region == RG_NET);
  assign cs_none = (region == RG_NONE);
endmodule

// File: rtl/fab_ram.sv
module fab_ram #(
  parameter int DW = 16,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && wr) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (cs && rd) q <= mem[idx];
  end
endmodule

// File: rtl/fab_rom.sv
module fab_rom #(
  parameter int DW = 16,
  parameter int IW = 11,
  parameter logic [DW-1:0] MULT = 16'h9E37,
  parameter logic [DW-1:0] MASK = 16'h5A5A
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          rd,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] q
);
  localparam int PW = DW + IW;

  function automatic logic [DW-1:0] rom_word(input logic [IW-1:0] i);
    logic [PW-1:0] prod;
    prod = PW'(i) * PW'(MULT);
    return prod[DW-1:0] ^ MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (cs && rd) q <= rom_word(idx);
  end
endmodule

// File: rtl/ctl_bus_fabric.sv
module ctl_bus_fabric
  import fab_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  input  logic          ext_ready,
  output logic          ext_sel_smp,
  output logic          ext_sel_net,
  output logic          ext_drive,
  inout  wire  [DW-1:0] ext_data
);
  localparam int RW = AW - IW;

  region_e       region;
  logic          cs_rom, cs_ram, cs_smp, cs_net, cs_none;
  logic [DW-1:0] rom_q, ram_q;
  logic          mem_sel, ack_q;

  fab_decode #(.AW(AW), .RW(RW)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .region(region),
    .cs_rom(cs_rom), .cs_ram(cs_ram), .cs_smp(cs_smp),
    .cs_net(cs_net), .cs_none(cs_none)
  );

  fab_rom #(.DW(DW), .IW(IW)) u_rom (
    .clk(clk), .cs(cs_rom), .rd(bus_rd), .idx(bus_addr[IW-1:0]), .q(rom_q)
  );

  fab_ram #(.DW(DW), .IW(IW)) u_ram (
    .clk(clk), .cs(cs_ram), .rd(bus_rd), .wr(bus_wr),
    .idx(bus_addr[IW-1:0]), .wdata(bus_wdata), .q(ram_q)
  );

  assign mem_sel = cs_rom | cs_ram;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= mem_sel & ~ack_q;
  end

  assign bus_ack = (mem_sel & ack_q) | ((cs_smp | cs_net) & ext_ready) | cs_none;

  always_comb begin
    unique case (region)
      RG_ROM:         bus_rdata = rom_q;
      RG_RAM:         bus_rdata = ram_q;
      RG_SMP, RG_NET: bus_rdata = ext_data;
      default:        bus_rdata = '0;
    endcase
  end

  assign ext_sel_smp = cs_smp;
  assign ext_sel_net = cs_net;
  assign ext_drive   = bus_wr & (cs_smp | cs_net);
  assign ext_data    = ext_drive ? bus_wdata : 'z;
endmodule

// File: rtl/ctl_bus_fabric_chk.sv
module ctl_bus_fabric_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [15:0] bus_rdata,
  input logic        bus_ack,
  input logic        ext_ready,
  input logic        ext_sel_smp,
  input logic        ext_sel_net,
  input logic        ext_drive
);
  logic [4:0] code;
  logic       stb;
  assign code = bus_addr[15:11];
  assign stb  = bus_rd | bus_wr;

  p_net_sel_r1: assert property (@(posedge clk) disable iff (rst)
    ext_sel_net |-> (stb && code == 5'd3));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !stb |-> (!bus_ack && !ext_sel_smp && !ext_sel_net && bus_rdata == 16'h0));

  p_mem_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_rd) && code < 5'd2) |-> !bus_ack);

  p_ext_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (stb && (code == 5'd2 || code == 5'd3)) |-> (bus_ack == ext_ready));

  p_drive_r7: assert property (@(posedge clk) disable iff (rst)
    ext_drive |-> (bus_wr && (ext_sel_smp || ext_sel_net)));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (stb && code > 5'd3) |-> (bus_ack && bus_rdata == 16'h0 && !ext_sel_smp && !ext_sel_net));
endmodule

bind ctl_bus_fabric ctl_bus_fabric_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .bus_ack(bus_ack), .ext_ready(ext_ready),
  .ext_sel_smp(ext_sel_smp), .ext_sel_net(ext_sel_net), .ext_drive(ext_drive)
);

// File: tb/ctl_bus_fabric_test.sv
`timescale 1ns/1ps
module ctl_bus_fabric_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack, ext_ready = 1'b0;
  logic        ext_sel_smp, ext_sel_net, ext_drive;
  wire  [15:0] ext_data;
  logic        tb_oe = 1'b0;
  logic [15:0] tb_val = '0;
  int          checks = 0, errors = 0;
  int          ram_model [int];

  assign ext_data = tb_oe ? tb_val : 16'hzzzz;

  always #4 clk = ~clk;

  ctl_bus_fabric uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .ext_ready(ext_ready), .ext_sel_smp(ext_sel_smp), .ext_sel_net(ext_sel_net),
    .ext_drive(ext_drive), .ext_data(ext_data)
  );

  function automatic logic [15:0] rom_ref(input int i);
    return 16'((i * 40503) % 65536) ^ 16'h5A5A;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference of the selects, away from both edges
  initial begin
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        check("R1 smp select", {15'b0, ext_sel_smp},
              {15'b0, (bus_rd || bus_wr) && bus_addr[15:11] == 5'd2});
        check("R1 net select", {15'b0, ext_sel_net},
              {15'b0, (bus_rd || bus_wr) && bus_addr[15:11] == 5'd3});
        check("R7 drive", {15'b0, ext_drive},
              {15'b0, bus_wr && (bus_addr[15:11] == 5'd2 || bus_addr[15:11] == 5'd3)});
      end
    end
  end

  task automatic mem_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !wr; bus_wr = wr;
    #1 check({req, " R5 no ack first cycle"}, {15'b0, bus_ack}, 16'h0);
    @(negedge clk); #1;
    check({req, " R5 ack second cycle"}, {15'b0, bus_ack}, 16'h1);
    if (!wr) check({req, " data"}, bus_rdata, exp);
    bus_rd = 1'b0; bus_wr = 1'b0;
    if (wr && a[15:11] == 5'd1) ram_model[int'(a[10:0])] = int'(d);
  endtask

  task automatic ext_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input logic rdy);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !wr; bus_wr = wr; ext_ready = rdy;
    tb_oe = !wr; tb_val = d;
    #1;
    check("R6 ack follows ready", {15'b0, bus_ack}, {15'b0, rdy});
    if (wr) check("R7 bus carries write data", ext_data, d);
    else    check("R6 read of external bus", bus_rdata, d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; ext_ready = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic unmapped(input bit wr, input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = !wr; bus_wr = wr; bus_wdata = 16'hFFFF;
    #1;
    check("R8 immediate ack", {15'b0, bus_ack}, 16'h1);
    check("R8 zero data", bus_rdata, 16'h0);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R9 ack low in reset", {15'b0, bus_ack}, 16'h0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R9 ack low after reset", {15'b0, bus_ack}, 16'h0);
    check("R2 idle rdata zero", bus_rdata, 16'h0);

    // RAM writes at both ends and middle, then readback (R3)
    mem_access(1, 16'h0800, 16'hA5C3, 0, "R3 write");
    mem_access(1, 16'h0FFF, 16'h1234, 0, "R3 write");
    mem_access(1, 16'h0A55, 16'h0F0F, 0, "R3 write");
    mem_access(0, 16'h0800, 0, 16'hA5C3, "R3 read idx0");
    mem_access(0, 16'h0FFF, 0, 16'h1234, "R3 read idx2047");
    mem_access(1, 16'h0A56, 16'hBEEF, 0, "R3 write neighbour");
    mem_access(0, 16'h0A55, 0, 16'(ram_model[int'(11'h255)]), "R3 read unchanged");
    mem_access(0, 16'h0A56, 0, 16'hBEEF, "R3 read neighbour");

    // ROM reads and write ignored (R4)
    mem_access(0, 16'h0000, 0, rom_ref(0), "R4 rom 0");
    mem_access(0, 16'h0001, 0, rom_ref(1), "R4 rom 1");
    mem_access(0, 16'h07FF, 0, rom_ref(2047), "R4 rom 2047");
    mem_access(1, 16'h0123, 16'hFFFF, 0, "R4 rom write");
    mem_access(0, 16'h0123, 0, rom_ref(291), "R4 rom after write");

    // external windows (R1, R6, R7)
    ext_access(0, 16'h1000, 16'hC0DE, 1'b1);
    ext_access(0, 16'h17FF, 16'h4321, 1'b0);
    ext_access(1, 16'h1800, 16'h9ABC, 1'b1);
    ext_access(1, 16'h1FFF, 16'h0055, 1'b0);
    ext_access(0, 16'h1A00, 16'h7777, 1'b1);

    // unmapped (R8)
    unmapped(0, 16'h2000);
    unmapped(1, 16'hF800);
    unmapped(0, 16'hFFFF);

    // idle again (R2)
    @(negedge clk); #1;
    check("R2 idle ack low", {15'b0, bus_ack}, 16'h0);
    check("R2 idle rdata zero", bus_rdata, 16'h0);
    mem_access(0, 16'h0800, 0, 16'hA5C3, "R3 read after traffic");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule